// File: doc/BRIEF.md
# Bus Ownership Arbiter with DMA Acknowledge Timing

This block decides which of four possible masters owns the shared bus: the DRAM refresh unit, an external master, and two DMA channels. Each DMA channel raises its request from an external request pin, from an internal peripheral line, or from a software request bit. The software bit is what lets a channel run memory-to-memory transfers with no peripheral involved. The external master uses a hold request and acknowledge handshake. The refresh unit has an internal request line and a done strobe. While refresh owns the bus, the block drives an active-low refresh status output.

A request seen while the bus is free starts a run of idle transition cycles, TI_CYCLES of them. The grant follows at the end of that run. Each owner keeps the bus until it releases it: a DMA channel through its transfer-done input, the external master by dropping hold, and refresh through its done strobe. After a release the bus passes through idle again before the next owner gets it.

Each DMA channel has an active-low acknowledge. Its shape depends on the channel's mode bit, which is captured when the grant starts. In fly-by mode the acknowledge stays low for the whole ownership. In two-cycle mode it is low only while the cycle engine's phase input marks the cycle that accesses the requesting device.

Top module: `busown_arbiter`

## Requirements
- R1: When several requesters compete, the bus goes to the highest one in this fixed order: refresh first, then the external hold request, then DMA channel 0, then DMA channel 1.
- R2: A DMA channel requests the bus when its request pin, its internal peripheral line or its software request bit is high.
- R3: A one-cycle pulse on a channel's software-set input makes its software request bit high on the next clock. The bit clears itself when that channel's transfer-done input is high while the channel holds the grant, so no new grant follows.
- R4: In any clock, at most one of the following is active: the DMA grants, the hold acknowledge and refresh ownership.
- R5: A request seen with the bus free is granted after TI_CYCLES idle transition cycles, which is TI_CYCLES+1 clocks after it is sampled. An owner is never replaced directly by another: at least TI_CYCLES+1 clocks without any grant lie between two owners.
- R6: An owner keeps the bus until it releases it: DMA channel i by transfer-done bit i, the external master by dropping hold_req, refresh by rfsh_done. Dropping a DMA request pin during ownership does not end the grant. The grant falls on the clock after the release.
- R7: With mode bit 1 (fly-by), a channel's dack_n is low in every cycle that channel is granted, whatever the phase input does.
- R8: With mode bit 0 (two-cycle), a channel's dack_n is low only while the channel is granted and io_phase is 1. At all other times dack_n is high.
- R9: A channel's mode bit is captured in the cycle before its grant appears. Changes to the mode input during the ownership have no effect on dack_n.
- R10: hold_ack answers hold_req. If the requester that won chosen during the idle transition withdraws its request before the grant (for example, hold_req falls), the arbiter returns to idle and gives no grant.
- R11: rfsh_n is low exactly in the cycles in which the refresh unit owns the bus.
- R12: During and after reset there is no grant. hold_ack is 0, rfsh_n is 1, every dack_n is 1, and the software request bits are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| drq_pin | input | NCH | External DMA request per channel |
| drq_int | input | NCH | Internal peripheral DMA request per channel |
| sw_req_set | input | NCH | Pulse that sets the channel's software request bit |
| xfer_done | input | NCH | Channel transfer complete; releases the channel's grant |
| mode_flyby | input | NCH | 1 = fly-by, 0 = two-cycle acknowledge |
| io_phase | input | 1 | High during the cycle that accesses the requesting device |
| hold_req | input | 1 | External master bus request |
| hold_ack | output | 1 | External master bus grant |
| rfsh_req | input | 1 | Refresh unit bus request |
| rfsh_done | input | 1 | Refresh cycle finished; releases the bus |
| rfsh_n | output | 1 | Low while refresh owns the bus |
| dma_grant | output | NCH | Bus grant per DMA channel, to the cycle engine |
| dack_n | output | NCH | Active-low DMA acknowledge per channel |

## Verification
Arbitration is tried with single requests on every source: each pin, each internal line and each software bit, plus hold and refresh. This shows that every request path reaches the grant logic. It is also tried with mixed request sets, such as all sources at once, hold with both channels, and a pin on one channel with an internal line on the other. Only the fixed order separates the winners in those sets. The grant is sampled one clock before and exactly at the expected latency, which catches both an early grant and a missing idle cycle. Overlapping channel requests with a hand-over show the idle gap between owners. Phase toggling under each mode tells fly-by apart from two-cycle acknowledge, and a mode change during ownership shows that the mode is captured at grant time.

// File: rtl/busown_pkg.sv
package busown_pkg;

    // Arbiter sequencing states
    typedef enum logic [1:0] {
        ARB_IDLE  = 2'd0,
        ARB_TRANS = 2'd1,
        ARB_OWN   = 2'd2
    } arb_state_e;

    // Slot positions in the request vector; lower index wins
    localparam int SLOT_RFSH = 0;
    localparam int SLOT_HOLD = 1;
    localparam int SLOT_DMA0 = 2;

endpackage

// File: rtl/busown_chan_req.sv
module busown_chan_req (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic int_i,
    input  logic sw_set_i,
    input  logic done_i,
    input  logic granted_i,
    output logic req_o
);

    typedef struct packed {
        logic sw;
    } creq_t;

    creq_t cur_q, nxt_d;

    always_comb begin
        nxt_d    = cur_q;
        // completion of an owned transfer drops the software bit; a new set wins
        nxt_d.sw = (cur_q.sw & ~(done_i & granted_i)) | sw_set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign req_o = pin_i | int_i | cur_q.sw;

    // R3: software bit self-clears on an owned completion
    assert_sw_selfclear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.sw && done_i && granted_i && !sw_set_i) |=> !cur_q.sw);

    // R3: a set pulse always leaves the bit high
    assert_sw_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sw_set_i |=> cur_q.sw);

endmodule

// File: rtl/busown_dack_gen.sv
module busown_dack_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic granted_i,
    input  logic flyby_i,
    input  logic io_phase_i,
    output logic dack_n_o
);

    typedef struct packed {
        logic flyby;
    } dack_t;

    dack_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        // follow the mode input only while not owning; frozen during ownership
        if (!granted_i) nxt_d.flyby = flyby_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '{flyby: 1'b1};
        else        cur_q <= nxt_d;
    end

    assign dack_n_o = ~(granted_i & (cur_q.flyby | io_phase_i));

    // R8: acknowledge never appears without the grant
    assert_dack_needs_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !dack_n_o |-> granted_i);

    // R9: captured mode does not move during an ownership
    assert_mode_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (granted_i && $past(granted_i)) |-> $stable(cur_q.flyby));

endmodule

// File: rtl/busown_grant_fsm.sv
module busown_grant_fsm
    import busown_pkg::*;
#(
    parameter int NREQ      = 4,
    parameter int TI_CYCLES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] req_i,
    input  logic [NREQ-1:0] rel_i,
    output logic [NREQ-1:0] grant_o
);

    localparam int CW = (TI_CYCLES > 1) ? $clog2(TI_CYCLES) : 1;

    typedef struct packed {
        arb_state_e      st;
        logic [NREQ-1:0] pend;
        logic [CW-1:0]   cnt;
    } fsm_t;

    fsm_t cur_q, nxt_d;
    logic [NREQ-1:0] winner;

    // lowest index request wins
    always_comb begin
        winner = '0;
        for (int i = NREQ - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                winner    = '0;
                winner[i] = 1'b1;
            end
        end
    end

    always_comb begin
        nxt_d = cur_q;
        case (cur_q.st)
            ARB_IDLE: begin
                if (|req_i) begin
                    nxt_d.st   = ARB_TRANS;
                    nxt_d.pend = winner;
                    nxt_d.cnt  = CW'(TI_CYCLES - 1);
                end
            end
            ARB_TRANS: begin
                if (!(|(cur_q.pend & req_i))) begin
                    nxt_d.st   = ARB_IDLE;
                    nxt_d.pend = '0;
                end else if (cur_q.cnt == '0) begin
                    nxt_d.st = ARB_OWN;
                end else begin
                    nxt_d.cnt = cur_q.cnt - 1'b1;
                end
            end
            ARB_OWN: begin
                if (|(cur_q.pend & rel_i)) begin
                    nxt_d.st   = ARB_IDLE;
                    nxt_d.pend = '0;
                end
            end
            default: begin
                nxt_d.st   = ARB_IDLE;
                nxt_d.pend = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '{st: ARB_IDLE, pend: '0, cnt: '0};
        else        cur_q <= nxt_d;
    end

    assign grant_o = (cur_q.st == ARB_OWN) ? cur_q.pend : '0;

    // R4: single owner
    assert_single_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    // R5: no direct owner-to-owner switch
    assert_idle_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant_o) |=> (grant_o == '0 || grant_o == $past(grant_o)));

    // R6: ownership kept while no release arrives
    assert_keep_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((|grant_o) && !(|(grant_o & rel_i))) |=> (grant_o == $past(grant_o)));

    // R5: a grant never appears straight out of idle
    assert_no_instant_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ARB_IDLE) |=> (grant_o == '0));

endmodule

// File: rtl/busown_arbiter.sv
module busown_arbiter
    import busown_pkg::*;
#(
    parameter int NCH       = 2,
    parameter int TI_CYCLES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] drq_pin,
    input  logic [NCH-1:0] drq_int,
    input  logic [NCH-1:0] sw_req_set,
    input  logic [NCH-1:0] xfer_done,
    input  logic [NCH-1:0] mode_flyby,
    input  logic           io_phase,
    input  logic           hold_req,
    output logic           hold_ack,
    input  logic           rfsh_req,
    input  logic           rfsh_done,
    output logic           rfsh_n,
    output logic [NCH-1:0] dma_grant,
    output logic [NCH-1:0] dack_n
);

    localparam int NREQ = NCH + SLOT_DMA0;

    logic [NREQ-1:0] req_vec;
    logic [NREQ-1:0] rel_vec;
    logic [NREQ-1:0] grant_vec;
    logic [NCH-1:0]  chan_req;

    assign req_vec[SLOT_RFSH] = rfsh_req;
    assign req_vec[SLOT_HOLD] = hold_req;
    assign rel_vec[SLOT_RFSH] = rfsh_done;
    assign rel_vec[SLOT_HOLD] = ~hold_req;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        assign req_vec[SLOT_DMA0 + c] = chan_req[c];
        assign rel_vec[SLOT_DMA0 + c] = xfer_done[c];
        assign dma_grant[c]           = grant_vec[SLOT_DMA0 + c];

        busown_chan_req u_req (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_i     (drq_pin[c]),
            .int_i     (drq_int[c]),
            .sw_set_i  (sw_req_set[c]),
            .done_i    (xfer_done[c]),
            .granted_i (grant_vec[SLOT_DMA0 + c]),
            .req_o     (chan_req[c])
        );

        busown_dack_gen u_dack (
            .clk        (clk),
            .rst_n      (rst_n),
            .granted_i  (grant_vec[SLOT_DMA0 + c]),
            .flyby_i    (mode_flyby[c]),
            .io_phase_i (io_phase),
            .dack_n_o   (dack_n[c])
        );
    end

    busown_grant_fsm #(
        .NREQ      (NREQ),
        .TI_CYCLES (TI_CYCLES)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_vec),
        .rel_i   (rel_vec),
        .grant_o (grant_vec)
    );

    assign hold_ack = grant_vec[SLOT_HOLD];
    assign rfsh_n   = ~grant_vec[SLOT_RFSH];

    // R11: refresh status only with the refresh grant
    assert_rfsh_status_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rfsh_n |-> (dma_grant == '0 && !hold_ack));

    // R12: quiet outputs right after reset
    assert_reset_quiet_R12: assert property (@(posedge clk)
        $rose(rst_n) |-> (dma_grant == '0 && !hold_ack && rfsh_n && (&dack_n)));

endmodule

// File: tb/busown_arbiter_test.sv
module busown_arbiter_test;

    localparam int NCH = 2;
    localparam int TI  = 2;
    localparam int LAT = TI + 1;
    localparam int NV  = 11;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic           rst_n;
    logic [NCH-1:0] drq_pin, drq_int, sw_req_set, xfer_done, mode_flyby;
    logic           io_phase, hold_req, rfsh_req, rfsh_done;
    logic           hold_ack, rfsh_n;
    logic [NCH-1:0] dma_grant, dack_n;

    busown_arbiter #(.NCH(NCH), .TI_CYCLES(TI)) uut (
        .clk(clk), .rst_n(rst_n), .drq_pin(drq_pin), .drq_int(drq_int),
        .sw_req_set(sw_req_set), .xfer_done(xfer_done), .mode_flyby(mode_flyby),
        .io_phase(io_phase), .hold_req(hold_req), .hold_ack(hold_ack),
        .rfsh_req(rfsh_req), .rfsh_done(rfsh_done), .rfsh_n(rfsh_n),
        .dma_grant(dma_grant), .dack_n(dack_n)
    );

    int n_run  = 0;
    int n_fail = 0;

    // vector: {rfsh, hold, int1, int0, pin1, pin0, winner}
    // winner: 0 none, 1 refresh, 2 hold, 3 channel 0, 4 channel 1
    localparam logic [8:0] VECS [NV] = '{
        9'b000001_011, 9'b000010_100, 9'b000100_011, 9'b001000_100,
        9'b000011_011, 9'b010011_010, 9'b100000_001, 9'b111111_001,
        9'b010010_010, 9'b001001_011, 9'b000000_000
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] obs();
        return {4'b0, ~rfsh_n, hold_ack, dma_grant};
    endfunction

    function automatic logic [7:0] want(input logic [2:0] code);
        case (code)
            3'd1:    return 8'b1000;
            3'd2:    return 8'b0100;
            3'd3:    return 8'b0001;
            3'd4:    return 8'b0010;
            default: return 8'b0000;
        endcase
    endfunction

    task automatic release_all();
        drq_pin = '0; drq_int = '0; hold_req = 1'b0; rfsh_req = 1'b0;
        xfer_done = '1; rfsh_done = 1'b1;
        tick(1);
        xfer_done = '0; rfsh_done = 1'b0;
        tick(1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; drq_pin = '0; drq_int = '0; sw_req_set = '0; xfer_done = '0;
        mode_flyby = '1; io_phase = 1'b0; hold_req = 1'b0; rfsh_req = 1'b0; rfsh_done = 1'b0;
        tick(3);
        chk("R12 reset owners", obs(), 8'h00);
        chk("R12 reset dack", {6'b0, dack_n}, 8'h03);
        rst_n = 1'b1;
        tick(LAT + 2);
        chk("R12 after reset no grant (sw bits clear)", obs(), 8'h00);

        // table walk: priority and request paths
        for (int k = 0; k < NV; k++) begin
            {rfsh_req, hold_req, drq_int[1], drq_int[0], drq_pin[1], drq_pin[0]} = VECS[k][8:3];
            tick(LAT - 1);
            chk($sformatf("R5 no early grant vec %0d", k), obs(), 8'h00);
            tick(1);
            chk($sformatf("R1 R2 R11 winner vec %0d", k), obs(), want(VECS[k][2:0]));
            chk($sformatf("R7 flyby dack vec %0d", k), {6'b0, dack_n}, {6'b0, ~want(VECS[k][2:0])} & 8'h03);
            release_all();
            chk($sformatf("R6 released vec %0d", k), obs(), 8'h00);
        end

        // R5: hand-over gap between two channels
        drq_pin = 2'b11;
        tick(LAT);
        chk("R5 ch0 first", obs(), 8'h01);
        drq_pin[0] = 1'b0; xfer_done[0] = 1'b1;
        tick(1);
        xfer_done[0] = 1'b0;
        chk("R6 ch0 dropped after done", obs(), 8'h00);
        tick(2);
        chk("R5 gap still idle", obs(), 8'h00);
        tick(1);
        chk("R5 ch1 after gap", obs(), 8'h02);
        release_all();

        // R6: pin drop does not end a DMA ownership
        drq_pin[0] = 1'b1;
        tick(LAT);
        drq_pin[0] = 1'b0;
        tick(3);
        chk("R6 held without done", obs(), 8'h01);
        release_all();

        // R3: software request, memory-to-memory path, self clear
        sw_req_set[1] = 1'b1;
        tick(1);
        sw_req_set[1] = 1'b0;
        tick(LAT);
        chk("R3 sw request granted", obs(), 8'h02);
        xfer_done[1] = 1'b1;
        tick(1);
        xfer_done[1] = 1'b0;
        tick(LAT + 2);
        chk("R3 sw bit self cleared", obs(), 8'h00);

        // R8: two-cycle acknowledge follows phase
        mode_flyby = 2'b00; drq_pin[0] = 1'b1;
        tick(LAT);
        chk("R8 two-cycle granted", obs(), 8'h01);
        chk("R8 dack off outside access", {6'b0, dack_n}, 8'h03);
        io_phase = 1'b1; #1;
        chk("R8 dack on in access", {6'b0, dack_n}, 8'h02);
        io_phase = 1'b0; #1;
        chk("R8 dack off again", {6'b0, dack_n}, 8'h03);
        mode_flyby[0] = 1'b1;
        tick(2);
        chk("R9 mode change ignored (two-cycle kept)", {6'b0, dack_n}, 8'h03);
        release_all();

        // R7 / R9: fly-by captured, phase and mode changes ignored
        mode_flyby = 2'b11; drq_pin[1] = 1'b1;
        tick(LAT);
        chk("R7 flyby dack low", {6'b0, dack_n}, 8'h01);
        io_phase = 1'b1; #1;
        chk("R7 flyby dack low with phase", {6'b0, dack_n}, 8'h01);
        io_phase = 1'b0; mode_flyby[1] = 1'b0;
        tick(2);
        chk("R9 mode change ignored (flyby kept)", {6'b0, dack_n}, 8'h01);
        release_all();
        mode_flyby = 2'b11;

        // R10: hold handshake and withdrawal in transition
        hold_req = 1'b1;
        tick(LAT);
        chk("R10 hold acknowledged", obs(), 8'h04);
        hold_req = 1'b0;
        tick(1);
        chk("R10 hold ack drops", obs(), 8'h00);
        tick(1);
        hold_req = 1'b1;
        tick(1);
        hold_req = 1'b0;
        tick(LAT + 1);
        chk("R10 withdrawn hold not granted", obs(), 8'h00);

        // R11: refresh status over a long ownership
        rfsh_req = 1'b1;
        tick(LAT + 3);
        chk("R11 refresh status held", obs(), 8'h08);
        rfsh_req = 1'b0; rfsh_done = 1'b1;
        tick(1);
        rfsh_done = 1'b0;
        chk("R11 refresh status off", {7'b0, rfsh_n}, 8'h01);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule